// File: doc/BRIEF.md
# Instruction Cache Refill Predecoder

This block sits on the refill path between the second-level memory and the instruction cache. Each fill beat brings a group of fixed-width 32-bit instruction words and the address of the first word. For every word, the block does a partial decode and appends a five-bit tag. The tag carries an instruction class, the execution unit the instruction will need, and a flag that says whether a branch target has already been worked out. The widened words then go on to be written into the cache.

The block computes targets only for PC-relative direct branches and jumps. For those it adds the sign-extended, word-scaled offset to the address of that instruction and outputs the result next to the tagged word. Indirect branches and unknown opcodes are tagged so that the later decode stage can tell them apart. Illegal opcodes get a class of their own, so decode can raise an exception for them.

Both sides use valid/ready handshakes. The block holds one register stage between input and output.

Top module: `icache_predecode`

## Requirements
- R1: While reset is held and just after it, `out_valid` is 0 and `in_ready` is 1.
- R2: A beat accepted on a clock edge (`in_valid` and `in_ready` both 1) appears on the outputs with `out_valid` = 1 right after that same edge. The latency is one cycle.
- R3: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_target` stay unchanged, `out_valid` stays 1 and `in_ready` is 0.
- R4: Lane i of `out_data` is the 37-bit field at bits [37*i+36 : 37*i]. The original instruction sits in the low 32 bits. The tag sits in the top 5 bits, laid out as {ready[4], unit[3:2], class[1:0]}. Lane i is the instruction at address `in_addr` + 4*i. Instruction bits are passed through unchanged.
- R5: The opcode is instruction bits [31:26]. Opcodes 0x00 and 0x08 get class 0 (compute) and unit 0 (integer). Opcode 0x11 gets class 0 and unit 2 (floating point). In all three cases ready is 0 and the target is 0.
- R6: Opcodes 0x20 (load) and 0x28 (store) get class 1 (memory), unit 1 (load/store), ready 0 and target 0.
- R7: Opcode 0x04 (conditional branch) gets class 2 (branch), unit 3 (branch unit) and ready 1. Its target is the lane address plus sign-extended bits [15:0] shifted left by 2.
- R8: Opcode 0x02 (direct jump) gets class 2, unit 3 and ready 1. Its target is the lane address plus sign-extended bits [25:0] shifted left by 2.
- R9: Opcode 0x03 (indirect jump) gets class 2 and unit 3, with ready 0 and target 0.
- R10: Every other opcode gets class 3 (illegal), unit 0, ready 0 and target 0.
- R11: With `out_ready` held at 1, the block accepts a new beat on every cycle and delivers each one in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Fill beat is present |
| in_ready | output | 1 | Block can take a beat |
| in_addr | input | 32 | Address of the first word of the beat |
| in_data | input | 128 | Four instruction words; word i at bits [32*i+31:32*i] |
| out_valid | output | 1 | Tagged beat is present |
| out_ready | input | 1 | Cache can take the tagged beat |
| out_data | output | 148 | Four tagged words of 37 bits each (R4) |
| out_target | output | 128 | Four computed branch targets; lane i at bits [32*i+31:32*i] |

## Verification
Each tagged beat, with its targets, is due exactly one clock edge after the edge that accepted it. The bench drives inputs on the falling edge and compares the outputs at the next falling edge, half a cycle after the register has updated. During the streaming run, each falling edge first checks the beat driven one cycle earlier and then drives the next one. That is how one beat per cycle in order is confirmed. In the stall test the bench checks the held output and `in_ready` on each stalled cycle. It then checks that the waiting beat replaces the held one exactly one edge after `out_ready` returns.

// File: rtl/icpd_pkg.sv
package icpd_pkg;

   typedef enum logic [1:0] {
      CLS_COMPUTE = 2'd0,
      CLS_MEMORY  = 2'd1,
      CLS_BRANCH  = 2'd2,
      CLS_ILLEGAL = 2'd3
   } cls_e;

   typedef enum logic [1:0] {
      UNIT_INT = 2'd0,
      UNIT_LSU = 2'd1,
      UNIT_FPU = 2'd2,
      UNIT_BRU = 2'd3
   } unit_e;

   typedef struct packed {
      logic  rdy;
      unit_e unit;
      cls_e  cls;
   } pd_tag_t;

   localparam int unsigned TAG_W = $bits(pd_tag_t);

   localparam logic [5:0] OP_ALU_REG = 6'h00;
   localparam logic [5:0] OP_ALU_IMM = 6'h08;
   localparam logic [5:0] OP_FP      = 6'h11;
   localparam logic [5:0] OP_LOAD    = 6'h20;
   localparam logic [5:0] OP_STORE   = 6'h28;
   localparam logic [5:0] OP_BCOND   = 6'h04;
   localparam logic [5:0] OP_JUMP    = 6'h02;
   localparam logic [5:0] OP_JREG    = 6'h03;

endpackage

// File: rtl/pd_lane.sv
module pd_lane
   import icpd_pkg::*;
#(
   parameter int unsigned INSN_W = 32,
   parameter int unsigned ADDR_W = 32
) (
   input  logic [INSN_W-1:0] insn,
   input  logic [ADDR_W-1:0] pc,
   output pd_tag_t           tag,
   output logic [ADDR_W-1:0] target
);
   localparam int unsigned SHORT_PAD = ADDR_W - 18;
   localparam int unsigned LONG_PAD  = ADDR_W - 28;

   logic [5:0]        opcode;
   logic [ADDR_W-1:0] short_off;
   logic [ADDR_W-1:0] long_off;

   assign opcode    = insn[31:26];
   assign short_off = {{SHORT_PAD{insn[15]}}, insn[15:0], 2'b00};
   assign long_off  = {{LONG_PAD{insn[25]}}, insn[25:0], 2'b00};

   always_comb begin
      tag    = '{rdy: 1'b0, unit: UNIT_INT, cls: CLS_ILLEGAL};
      target = '0;
      unique case (opcode)
         OP_ALU_REG, OP_ALU_IMM: begin
            tag.cls  = CLS_COMPUTE;
            tag.unit = UNIT_INT;
         end
         OP_FP: begin
            tag.cls  = CLS_COMPUTE;
            tag.unit = UNIT_FPU;
         end
         OP_LOAD, OP_STORE: begin
            tag.cls  = CLS_MEMORY;
            tag.unit = UNIT_LSU;
         end
         OP_BCOND: begin
            tag    = '{rdy: 1'b1, unit: UNIT_BRU, cls: CLS_BRANCH};
            target = pc + short_off;
         end
         OP_JUMP: begin
            tag    = '{rdy: 1'b1, unit: UNIT_BRU, cls: CLS_BRANCH};
            target = pc + long_off;
         end
         OP_JREG: begin
            tag.cls  = CLS_BRANCH;
            tag.unit = UNIT_BRU;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/pd_stage.sv
module pd_stage #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         up_valid,
   output logic         up_ready,
   input  logic [W-1:0] up_data,
   output logic         dn_valid,
   input  logic         dn_ready,
   output logic [W-1:0] dn_data
);
   logic         full_q;
   logic [W-1:0] data_q;

   assign up_ready = !full_q || dn_ready;
   assign dn_valid = full_q;
   assign dn_data  = data_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         data_q <= '0;
      end else if (up_ready) begin
         full_q <= up_valid;
         if (up_valid) data_q <= up_data;
      end
   end

   assert_accept_lat_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && up_ready) |=> (dn_valid && dn_data == $past(up_data)));

   assert_stall_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_data)));

   assert_stall_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_valid && !dn_ready) |-> !up_ready);
endmodule

// File: rtl/icache_predecode.sv
module icache_predecode
   import icpd_pkg::*;
#(
   parameter int unsigned LANES  = 4,
   parameter int unsigned INSN_W = 32,
   parameter int unsigned ADDR_W = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_valid,
   output logic                       in_ready,
   input  logic [ADDR_W-1:0]          in_addr,
   input  logic [LANES*INSN_W-1:0]    in_data,
   output logic                       out_valid,
   input  logic                       out_ready,
   output logic [LANES*(INSN_W+TAG_W)-1:0] out_data,
   output logic [LANES*ADDR_W-1:0]    out_target
);
   localparam int unsigned LANE_W  = INSN_W + TAG_W;
   localparam int unsigned DATA_W  = LANES * LANE_W;
   localparam int unsigned TGT_W   = LANES * ADDR_W;
   localparam int unsigned STAGE_W = DATA_W + TGT_W;
   localparam int unsigned STEP    = INSN_W / 8;

   if (INSN_W != 32) begin : g_bad_insn
      $error("INSN_W must be 32");
   end
   if (ADDR_W < 29) begin : g_bad_addr
      $error("ADDR_W must be at least 29");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("LANES must be at least 1");
   end

   logic [DATA_W-1:0]  wide_d;
   logic [TGT_W-1:0]   tgt_d;
   logic [STAGE_W-1:0] stage_q;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      pd_tag_t           tag;
      logic [ADDR_W-1:0] pc;
      logic [ADDR_W-1:0] tgt;

      assign pc = in_addr + ADDR_W'(STEP * i);

      pd_lane #(.INSN_W(INSN_W), .ADDR_W(ADDR_W)) lane_i (
         .insn   (in_data[i*INSN_W +: INSN_W]),
         .pc     (pc),
         .tag    (tag),
         .target (tgt)
      );

      assign wide_d[i*LANE_W +: LANE_W] = {tag, in_data[i*INSN_W +: INSN_W]};
      assign tgt_d[i*ADDR_W +: ADDR_W]  = tgt;
   end

   pd_stage #(.W(STAGE_W)) stage_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .up_valid (in_valid),
      .up_ready (in_ready),
      .up_data  ({tgt_d, wide_d}),
      .dn_valid (out_valid),
      .dn_ready (out_ready),
      .dn_data  (stage_q)
   );

   assign out_data   = stage_q[DATA_W-1:0];
   assign out_target = stage_q[STAGE_W-1:DATA_W];

   for (genvar i = 0; i < LANES; i++) begin : g_chk
      pd_tag_t           otag;
      logic [ADDR_W-1:0] otgt;
      assign otag = pd_tag_t'(out_data[i*LANE_W + INSN_W +: TAG_W]);
      assign otgt = out_target[i*ADDR_W +: ADDR_W];

      assert_illegal_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && otag.cls == CLS_ILLEGAL) |-> (!otag.rdy && otgt == '0));

      assert_ready_branch_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && otag.rdy) |-> (otag.cls == CLS_BRANCH && otag.unit == UNIT_BRU));

      assert_no_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && !otag.rdy) |-> (otgt == '0));
   end

   assert_reset_idle_R1: assert property (@(posedge clk)
      !rst_n |=> !out_valid);
endmodule

// File: tb/icache_predecode_tb_top.sv
module icache_predecode_tb_top;
   localparam int LANES = 4;
   localparam int NV    = 12;
   localparam int NB    = NV / LANES;

   localparam logic [31:0] V_INSN [NV] = '{
      32'h00221820, 32'h10000010, 32'h1000FFFE, 32'h80A20004,
      32'h08000100, 32'h0BFFFFFF, 32'h0FE00000, 32'hFC000000,
      32'h44000000, 32'hA0000000, 32'h20000000, 32'h04000000};
   localparam logic [4:0] V_TAG [NV] = '{
      5'h00, 5'h1E, 5'h1E, 5'h05,
      5'h1E, 5'h1E, 5'h0E, 5'h03,
      5'h08, 5'h05, 5'h00, 5'h03};
   localparam logic [31:0] V_TGT [NV] = '{
      32'h0, 32'h00001044, 32'h00001000, 32'h0,
      32'h00002400, 32'h00002000, 32'h0, 32'h0,
      32'h0, 32'h0, 32'h0, 32'h0};
   localparam string V_REQ [NV] = '{
      "R5", "R7", "R7", "R6", "R8", "R8", "R9", "R10",
      "R5", "R6", "R5", "R10"};

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic         in_ready;
   logic [31:0]  in_addr = '0;
   logic [127:0] in_data = '0;
   logic         out_valid;
   logic         out_ready = 1'b1;
   logic [147:0] out_data;
   logic [127:0] out_target;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   icache_predecode dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_addr(in_addr), .in_data(in_data), .out_valid(out_valid),
      .out_ready(out_ready), .out_data(out_data), .out_target(out_target));

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive_beat(input int b);
      in_valid = 1'b1;
      in_addr  = 32'h1000 * (b + 1);
      for (int l = 0; l < LANES; l++) in_data[l*32 +: 32] = V_INSN[b*LANES + l];
   endtask

   task automatic check_beat(input int b);
      check("R2", 64'(out_valid), 64'd1);
      for (int l = 0; l < LANES; l++) begin
         int k = b*LANES + l;
         check("R4", 64'(out_data[l*37 +: 32]), 64'(V_INSN[k]));
         check(V_REQ[k], 64'(out_data[l*37 + 32 +: 5]), 64'(V_TAG[k]));
         check(V_REQ[k], 64'(out_target[l*32 +: 32]), 64'(V_TGT[k]));
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #2000000;
      total++; bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1", 64'(out_valid), 64'd0);
      check("R1", 64'(in_ready), 64'd1);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", 64'(out_valid), 64'd0);
      check("R1", 64'(in_ready), 64'd1);

      // R11: stream every beat back to back, one result per cycle
      for (int b = 0; b < NB; b++) begin
         drive_beat(b);
         @(negedge clk);
         check("R11", 64'(in_ready), 64'd1);
         check_beat(b);
      end
      in_valid = 1'b0;
      @(negedge clk);
      check("R11", 64'(out_valid), 64'd0);

      // R3: stall with beat 0 held while beat 2 waits
      out_ready = 1'b0;
      drive_beat(0);
      @(negedge clk);
      check_beat(0);
      drive_beat(2);
      for (int c = 0; c < 3; c++) begin
         @(negedge clk);
         check("R3", 64'(in_ready), 64'd0);
         check_beat(0);
      end
      out_ready = 1'b1;
      @(negedge clk);
      check_beat(2);
      in_valid = 1'b0;
      @(negedge clk);
      check("R3", 64'(out_valid), 64'd0);

      // R1: reset mid-stream clears the output
      drive_beat(1);
      @(negedge clk);
      check_beat(1);
      in_valid = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      check("R1", 64'(out_valid), 64'd0);
      check("R1", 64'(in_ready), 64'd1);
      finish_run();
   end
endmodule